// File: doc/BRIEF.md
# Dithered-Duty PWM Output Channel

This block drives a single pulse-width-modulated pin from one of several shared timebases. A binary select picks one timer's count and overflow strobe. The output rises when that count matches a programmable rise point. It falls when the count matches a fall point, which is the rise point plus the integer part of a duty word. The duty word also carries a small binary fraction. A phase accumulator spreads that fraction over successive periods by lengthening some of them by one count. The average pulse width therefore has a resolution finer than one timer count.

New rise-point and duty values are taken only when the selected timer overflows, so a period already in progress is never cut short or stretched. While the channel is disabled, the pin shows a programmable idle level. The pulse logic keeps running in the background, so that when the channel is enabled again the pin resumes in phase.

Top module: `pwm_dither_chan`

## Requirements
- R1: The 2-bit select value k (0 to 3) makes timer k's count and overflow strobe drive the channel. The overflow strobes of the other timers have no effect.
- R2: While enabled, the output goes high one clock after the cycle in which the selected count equals the active rise point.
- R3: While enabled, the output goes low one clock after the cycle in which the selected count equals the active fall point. The fall point is the rise point plus duty bits [24:4], plus a lengthen bit e (0 or 1).
- R4: A 4-bit accumulator adds duty bits [3:0] at each selected overflow, and e for the following period is the carry out of that addition. The accumulator starts at zero after reset, so period j after reset has e = floor(j·f/16) − floor((j−1)·f/16), and any 16 consecutive periods with a constant fraction f contain exactly f lengthened ones.
- R5: While the enable input is low, the output equals the idle-level input in the same cycle. The pulse state keeps advancing, so the first period after re-enabling has the programmed width.
- R6: The rise point and duty are sampled only at a selected overflow. A change in mid-period leaves the current period unchanged and is applied from the next period.
- R7: When the active fall point equals the active rise point, the output is low for the whole period.
- R8: Reset clears the accumulator and both active points. An enabled output is then low until a new configuration is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timerCnt | input | 80 | Four 20-bit timer counts, timer k at bits [20k+19:20k] |
| timerOvf | input | 4 | Overflow strobes, bit k for timer k, high in the last count of a period |
| timerSel | input | 2 | Timer select |
| outEn | input | 1 | Channel enable |
| idleLvl | input | 1 | Output level while disabled |
| hPoint | input | 20 | Rise point |
| duty | input | 25 | Duty: bits [24:4] integer counts, bits [3:0] sixteenths |
| pwmOut | output | 1 | PWM pin |

## Verification
The hardest thing to reach from the ports is a known accumulator phase. Which periods get lengthened depends on every selected overflow since reset, including those seen under earlier select values. The bench therefore resets before each point of its sweep over all four timers and all sixteen fractions. It then numbers the periods from the first overflow, so the expected width of each period follows from the floor formula of R4. A second hard case is a configuration change landing inside a period. The bench writes new points one count after an overflow and checks the old and the new widths in turn.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;
  // Strobes passed from the dither control to the compare datapath.
  typedef struct packed {
    logic loadShadow;  // selected timer overflows this cycle
    logic addOne;      // next period is lengthened by one count
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_dither_ctrl.sv
module pwm_dither_ctrl
  import pwm_dither_pkg::*;
#(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selOvf,
  input  logic [FRAC_W-1:0] dutyFrac,
  output pwmStrobe_t        strobe
);
  logic [FRAC_W-1:0] phaseAcc;
  logic [FRAC_W:0]   phaseSum;

  assign phaseSum = {1'b0, phaseAcc} + {1'b0, dutyFrac};

  always_comb begin
    strobe.loadShadow = selOvf;
    strobe.addOne     = phaseSum[FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseAcc <= '0;
    end else if (selOvf) begin
      phaseAcc <= phaseSum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/pwm_dither_dp.sv
module pwm_dither_dp
  import pwm_dither_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int CNT_W      = 20,
  parameter int INT_W      = 21,
  parameter int SEL_W      = $clog2(NUM_TIMERS),
  parameter int LOW_W      = ((INT_W > CNT_W) ? INT_W : CNT_W) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_TIMERS*CNT_W-1:0] timerCnt,
  input  logic [NUM_TIMERS-1:0]       timerOvf,
  input  logic [SEL_W-1:0]            timerSel,
  input  logic [CNT_W-1:0]            hPoint,
  input  logic [INT_W-1:0]            dutyInt,
  input  pwmStrobe_t                  strobe,
  output logic                        selOvf,
  output logic [CNT_W-1:0]            selCnt,
  output logic [CNT_W-1:0]            hpShadow,
  output logic [LOW_W-1:0]            lowShadow,
  output logic                        pwmLevel
);
  logic [CNT_W-1:0] cntArr [NUM_TIMERS];

  for (genvar k = 0; k < NUM_TIMERS; k++) begin : gUnpack
    assign cntArr[k] = timerCnt[k*CNT_W +: CNT_W];
  end

  assign selCnt = cntArr[timerSel];
  assign selOvf = timerOvf[timerSel];

  // Fall point for the next period, with the dither carry folded in.
  logic [LOW_W-1:0] lowNext;
  assign lowNext = LOW_W'(hPoint) + LOW_W'(dutyInt) + LOW_W'(strobe.addOne);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpShadow  <= '0;
      lowShadow <= '0;
    end else if (strobe.loadShadow) begin
      hpShadow  <= hPoint;
      lowShadow <= lowNext;
    end
  end

  logic pointsEqual, hitLow, hitHigh, levelNext;
  assign pointsEqual = (LOW_W'(hpShadow) == lowShadow);
  assign hitLow      = (LOW_W'(selCnt) == lowShadow);
  assign hitHigh     = (selCnt == hpShadow);

  always_comb begin
    levelNext = pwmLevel;
    if (pointsEqual || hitLow) levelNext = 1'b0;
    else if (hitHigh)          levelNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwmLevel <= 1'b0;
    else        pwmLevel <= levelNext;
  end
endmodule

// File: rtl/pwm_dither_chan.sv
module pwm_dither_chan
  import pwm_dither_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int CNT_W      = 20,
  parameter int DUTY_W     = 25,
  parameter int FRAC_W     = 4,
  parameter int SEL_W      = $clog2(NUM_TIMERS),
  parameter int INT_W      = DUTY_W - FRAC_W,
  parameter int LOW_W      = ((INT_W > CNT_W) ? INT_W : CNT_W) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_TIMERS*CNT_W-1:0] timerCnt,
  input  logic [NUM_TIMERS-1:0]       timerOvf,
  input  logic [SEL_W-1:0]            timerSel,
  input  logic                        outEn,
  input  logic                        idleLvl,
  input  logic [CNT_W-1:0]            hPoint,
  input  logic [DUTY_W-1:0]           duty,
  output logic                        pwmOut
);
  pwmStrobe_t       strobe;
  logic             selOvf;
  logic [CNT_W-1:0] selCnt;
  logic [CNT_W-1:0] hpShadow;
  logic [LOW_W-1:0] lowShadow;
  logic             pwmLevel;

  pwm_dither_ctrl #(.FRAC_W(FRAC_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .selOvf   (selOvf),
    .dutyFrac (duty[FRAC_W-1:0]),
    .strobe   (strobe)
  );

  pwm_dither_dp #(
    .NUM_TIMERS (NUM_TIMERS),
    .CNT_W      (CNT_W),
    .INT_W      (INT_W),
    .SEL_W      (SEL_W),
    .LOW_W      (LOW_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .timerCnt  (timerCnt),
    .timerOvf  (timerOvf),
    .timerSel  (timerSel),
    .hPoint    (hPoint),
    .dutyInt   (duty[DUTY_W-1:FRAC_W]),
    .strobe    (strobe),
    .selOvf    (selOvf),
    .selCnt    (selCnt),
    .hpShadow  (hpShadow),
    .lowShadow (lowShadow),
    .pwmLevel  (pwmLevel)
  );

  assign pwmOut = outEn ? pwmLevel : idleLvl;
endmodule

// File: rtl/pwm_dither_chan_chk.sv
module pwm_dither_chan_chk #(
  parameter int CNT_W = 20,
  parameter int INT_W = 21,
  parameter int LOW_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             outEn,
  input logic             idleLvl,
  input logic             pwmOut,
  input logic [CNT_W-1:0] selCnt,
  input logic [CNT_W-1:0] hpShadow,
  input logic [LOW_W-1:0] lowShadow,
  input logic             loadShadow,
  input logic [INT_W-1:0] dutyInt
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2: a rising edge of the enabled output follows a rise-point match
  assert_rise_at_hpoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && outEn && $past(outEn) && $rose(pwmOut))
      |-> ($past(selCnt) == $past(hpShadow)));

  // R3 / R7: a falling edge follows a fall-point match or equal points
  assert_fall_at_lowpoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && outEn && $past(outEn) && $fell(pwmOut))
      |-> ((LOW_W'($past(selCnt)) == $past(lowShadow)) ||
           (LOW_W'($past(hpShadow)) == $past(lowShadow))));

  // R4: loaded fall point is rise point plus integer duty plus 0 or 1
  assert_lowpoint_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(loadShadow))
      |-> ((lowShadow - LOW_W'(hpShadow) == LOW_W'($past(dutyInt))) ||
           (lowShadow - LOW_W'(hpShadow) == LOW_W'($past(dutyInt)) + LOW_W'(1))));

  // R5: while disabled, the pin only moves with the idle level
  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !outEn && !$past(outEn) && $stable(idleLvl)) |-> $stable(pwmOut));

  // R6: active points change only after an overflow load
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(loadShadow)) |-> ($stable(hpShadow) && $stable(lowShadow)));

  // R7: equal active points keep the enabled output low
  assert_equal_points_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && outEn && (LOW_W'($past(hpShadow)) == $past(lowShadow))) |-> !pwmOut);
endmodule

bind pwm_dither_chan pwm_dither_chan_chk #(
  .CNT_W (CNT_W),
  .INT_W (INT_W),
  .LOW_W (LOW_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .outEn      (outEn),
  .idleLvl    (idleLvl),
  .pwmOut     (pwmOut),
  .selCnt     (selCnt),
  .hpShadow   (hpShadow),
  .lowShadow  (lowShadow),
  .loadShadow (strobe.loadShadow),
  .dutyInt    (duty[DUTY_W-1:FRAC_W])
);

// File: tb/pwm_dither_chan_tb_top.sv
module pwm_dither_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int CW = 20;
  localparam int DW = 25;
  localparam int FW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NT*CW-1:0] timerCnt = '0;
  logic [NT-1:0]  timerOvf = '0;
  logic [1:0]     timerSel = '0;
  logic           outEn = 1'b0;
  logic           idleLvl = 1'b0;
  logic [CW-1:0]  hPoint = '0;
  logic [DW-1:0]  duty = '0;
  logic           pwmOut;

  pwm_dither_chan dut_i (
    .clk(clk), .rst_n(rst_n), .timerCnt(timerCnt), .timerOvf(timerOvf),
    .timerSel(timerSel), .outEn(outEn), .idleLvl(idleLvl),
    .hPoint(hPoint), .duty(duty), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  int  tCnt [NT];
  logic sampOut;
  int  prevSel;
  int  curSel = 0;

  function automatic int periodOf(int k);
    return 16 + 4 * k;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: sample the pin after the rising edge, then advance the timers.
  task automatic tick();
    @(negedge clk);
    sampOut = pwmOut;
    prevSel = tCnt[curSel];
    for (int k = 0; k < NT; k++) begin
      tCnt[k] = (tCnt[k] == periodOf(k) - 1) ? 0 : tCnt[k] + 1;
      timerCnt[k*CW +: CW] = CW'(tCnt[k]);
      timerOvf[k] = (tCnt[k] == periodOf(k) - 1);
    end
  endtask

  task automatic setDuty(int di, int fr);
    duty = (DW'(di) << FW) | DW'(fr);
  endtask

  // Reset, configure, and stop right after the first selected overflow edge.
  task automatic startRun(int sel, int hp, int di, int fr, bit en, bit idle);
    rst_n = 1'b0;
    curSel = sel;
    timerSel = 2'(sel);
    hPoint = CW'(hp);
    setDuty(di, fr);
    outEn = en;
    idleLvl = idle;
    repeat (3) tick();
    if (en) check(sampOut == 1'b0, "R8 reset output", int'(sampOut), 0);
    rst_n = 1'b1;
    tick();
    while (prevSel != periodOf(sel) - 1) tick();
  endtask

  // One period of the selected timer; optional mid-period rewrite.
  task automatic measurePeriod(output int highs, output int firstHi, output int lastHi,
                               input int changeAt, input int newHp, input int newDi);
    highs = 0; firstHi = -1; lastHi = -1;
    for (int i = 0; i < periodOf(curSel); i++) begin
      if (i == changeAt) begin
        hPoint = CW'(newHp);
        setDuty(newDi, 0);
      end
      tick();
      if (sampOut) begin
        highs++;
        if (firstHi < 0) firstHi = prevSel;
        lastHi = prevSel;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 120000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int h, fh, lh, sum, hp, di, ej;
    for (int k = 0; k < NT; k++) tCnt[k] = 0;

    // Sweep: every timer, every fraction (R1, R2, R3, R4, R8).
    for (int sel = 0; sel < NT; sel++) begin
      for (int fr = 0; fr < 16; fr++) begin
        hp = 1 + sel;
        di = (fr == 15) ? 0 : 3 + sel;  // fr 15 also exercises zero integer duty
        startRun(sel, hp, di, fr, 1'b1, 1'b0);
        sum = 0;
        for (int j = 1; j <= 16; j++) begin
          ej = (j * fr) / 16 - ((j - 1) * fr) / 16;
          measurePeriod(h, fh, lh, -1, 0, 0);
          // R1 selection and R4 lengthen pattern show up in the width
          check(h == di + ej, "R1 R4 period width", h, di + ej);
          if (di + ej > 0) begin
            check(fh == hp, "R2 rise position", fh, hp);
            check(lh == hp + di + ej - 1, "R3 fall position", lh, hp + di + ej - 1);
          end
          sum += h - di;
        end
        check(sum == fr, "R4 lengthened count over 16 periods", sum, fr);
      end
    end

    // R6: mid-period rewrite applies from the next period.
    startRun(1, 3, 5, 0, 1'b1, 1'b0);
    measurePeriod(h, fh, lh, 1, 6, 9);
    check(h == 5, "R6 current period width kept", h, 5);
    check(fh == 3, "R6 current rise point kept", fh, 3);
    measurePeriod(h, fh, lh, -1, 0, 0);
    check(h == 9, "R6 new width applied", h, 9);
    check(fh == 6, "R6 new rise point applied", fh, 6);

    // R7: equal points keep the pin low.
    startRun(2, 5, 0, 0, 1'b1, 1'b0);
    for (int j = 0; j < 3; j++) begin
      measurePeriod(h, fh, lh, -1, 0, 0);
      check(h == 0, "R7 equal points low", h, 0);
    end

    // R5: idle level while disabled, then in-phase restart.
    startRun(0, 2, 4, 0, 1'b0, 1'b1);
    measurePeriod(h, fh, lh, -1, 0, 0);
    check(h == periodOf(0), "R5 idle high", h, periodOf(0));
    idleLvl = 1'b0;
    measurePeriod(h, fh, lh, -1, 0, 0);
    check(h == 0, "R5 idle low", h, 0);
    outEn = 1'b1;
    measurePeriod(h, fh, lh, -1, 0, 0);
    check(h == 4, "R5 re-enabled width", h, 4);
    check(fh == 2, "R5 re-enabled rise", fh, 2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule